// File: doc/BRIEF.md
# RAM bank address remapper

This block sits between a small processor core and a 1 KB on-chip data RAM and decides which physical byte each access reaches. Two special-function registers, written and read over a byte-wide register bus, hold the mapping state. The bank register redirects the direct-address window 0x40 to 0x7F onto any 64-byte slice of the RAM when its enable bit is set. The page register supplies the upper address bits for 8-bit indirect external-data accesses, giving three 256-byte pages.

Both address paths are purely combinational from the registers, so a register write changes the mapping for the very next access. Page code 3 names no RAM; the block blocks the write and returns 0xFF on reads for such accesses. The core, the RAM array and the rest of the chip sit outside this block.

Top module: `ram_bank_remap`

## Requirements
- R1: After synchronous active-low reset, the bank register reads 0x01 (enable 0, bank 1) and the page register reads 0x00.
- R2: A write to register address 0x86 stores bit 7 as the enable and bits 3:0 as the bank number. Bits 6:4 are discarded and read back as 0.
- R3: A write to register address 0x85 stores bits 1:0 as the page code. Bits 7:2 are discarded and read back as 0.
- R4: When the read strobe is high at address 0x85 or 0x86, `sfr_rd_hit` is 1 and `sfr_rdata` shows that register in the same cycle. Otherwise `sfr_rd_hit` is 0 and `sfr_rdata` is 0x00.
- R5: When the enable bit is 1 and `dir_addr` is in 0x40 to 0x7F, `dir_phys` = {bank[3:0], dir_addr[5:0]}.
- R6: When the enable bit is 0, or `dir_addr` is outside 0x40 to 0x7F, `dir_phys` = {2'b00, dir_addr}.
- R7: For page codes 0, 1 and 2, `ext_phys` = {page, ext_addr}. This keeps it within 0x000 to 0x2FF, and `ext_valid` is 1.
- R8: With page code 3, `ext_valid` is 0, `ext_ram_we` stays 0 whatever `ext_wr_req` is, and `ext_rdata` is 0xFF. With a valid page, `ext_ram_we` follows `ext_wr_req` and `ext_rdata` follows `ram_rdata`.
- R9: A write strobe at any address other than 0x85 or 0x86 leaves both registers unchanged.
- R10: A register write captured on a clock edge sets the mapping seen on `dir_phys` and `ext_phys` in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rd | input | 1 | Register read strobe |
| sfr_rdata | output | 8 | Register read data, 0 when not selected |
| sfr_rd_hit | output | 1 | High when this block answers the read |
| dir_addr | input | 8 | Direct internal-RAM address from the core |
| dir_phys | output | 10 | Physical RAM address for the direct access |
| ext_addr | input | 8 | Low byte of an 8-bit indirect external access |
| ext_wr_req | input | 1 | The core requests an external-data write |
| ram_rdata | input | 8 | Data read from the RAM array |
| ext_phys | output | 10 | Physical RAM address for the external access |
| ext_valid | output | 1 | The page code selects real RAM |
| ext_ram_we | output | 1 | Write enable to the RAM for the external access |
| ext_rdata | output | 8 | Read data returned to the core |

## Verification
The embedded properties assume that the register strobes and addresses are stable, known values at every rising edge outside reset. They also assume that a write and the check of its effect are one edge apart, so `$past` of the write data is meaningful. The bench drives every input on the falling edge and releases strobes one cycle later, so no strobe is ever partly captured. The bench also keeps `sfr_addr` defined while the strobes are low, so the hold property always sees real values.

// File: rtl/ram_remap_pkg.sv
// Package: shared widths, SFR encodings and the bank-config type for the
// RAM bank remapper. Assumes an 8-bit data path and a 1 KB target array.
package ram_remap_pkg;
    localparam int DW      = 8;                 // register / data width
    localparam int BANK_W  = 4;                 // bank number width
    localparam int PAGE_W  = 2;                 // page code width
    localparam int SLICE_W = 6;                 // 64-byte slice offset
    localparam int PHYS_W  = BANK_W + SLICE_W;  // 1 KB physical address
    localparam int EXT_W   = 8;                 // indirect address width
    localparam int PAD_W   = PHYS_W - DW;       // zero pad for pass-through
    localparam logic [DW-SLICE_W-1:0] WIN_TAG = 2'b01; // window 0x40-0x7F
    localparam logic [PAGE_W-1:0] PAGE_BAD = 2'b11;    // page with no RAM

    typedef struct packed {
        logic              en;
        logic [BANK_W-1:0] num;
    } bank_cfg_t;
endpackage

// File: rtl/remap_sfr_regs.sv
// Module: remap_sfr_regs
// Holds the bank and page registers and serves register-bus reads.
// Assumes strobes are single-cycle-qualified by the clock; reads are
// combinational, writes take effect on the capturing edge.
module remap_sfr_regs
    import ram_remap_pkg::*;
#(
    parameter logic [DW-1:0]     BANK_ADDR = 8'h86,
    parameter logic [DW-1:0]     PAGE_ADDR = 8'h85,
    parameter logic [BANK_W-1:0] BANK_RST  = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     sfr_addr,
    input  logic              sfr_wr,
    input  logic [DW-1:0]     sfr_wdata,
    input  logic              sfr_rd,
    output logic [DW-1:0]     sfr_rdata,
    output logic              sfr_rd_hit,
    output bank_cfg_t         bank_q,
    output logic [PAGE_W-1:0] page_q
);
    localparam int BANK_GAP = DW - 1 - BANK_W;
    localparam logic [DW-1:0] BANK_MASK =
        {1'b1, {BANK_GAP{1'b0}}, {BANK_W{1'b1}}};
    localparam logic [DW-1:0] PAGE_MASK = {{(DW-PAGE_W){1'b0}}, {PAGE_W{1'b1}}};

    logic [DW-1:0] bank_view;
    logic [DW-1:0] page_view;
    logic          hit_bank;
    logic          hit_page;

    assign hit_bank = (sfr_addr == BANK_ADDR);
    assign hit_page = (sfr_addr == PAGE_ADDR);

    // Bank register: enable bit and bank number, unused bits not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.en  <= 1'b0;
            bank_q.num <= BANK_RST;
        end else if (sfr_wr && hit_bank) begin
            bank_q.en  <= sfr_wdata[DW-1];
            bank_q.num <= sfr_wdata[BANK_W-1:0];
        end
    end

    // Page register: only the page code bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (sfr_wr && hit_page) begin
            page_q <= sfr_wdata[PAGE_W-1:0];
        end
    end

    // Read view: rebuild the byte images with zeros in unused positions.
    always_comb begin
        bank_view  = {bank_q.en, {BANK_GAP{1'b0}}, bank_q.num};
        page_view  = {{(DW-PAGE_W){1'b0}}, page_q};
        sfr_rd_hit = sfr_rd && (hit_bank || hit_page);
        sfr_rdata  = '0;
        if (sfr_rd && hit_bank)      sfr_rdata = bank_view;
        else if (sfr_rd && hit_page) sfr_rdata = page_view;
    end

    // R2: stored bank image equals written byte with unused bits cleared
    assert_bank_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && hit_bank) |=> (bank_view == ($past(sfr_wdata) & BANK_MASK)));

    // R3: stored page image equals written byte with upper bits cleared
    assert_page_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && hit_page) |=> (page_view == ($past(sfr_wdata) & PAGE_MASK)));

    // R9: no matching write, no change
    assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sfr_wr || (!hit_bank && !hit_page)) |=> ($stable(bank_q) && $stable(page_q)));
endmodule

// File: rtl/remap_direct.sv
// Module: remap_direct
// Translates a direct internal-RAM address into a 1 KB physical address.
// Assumes the bank config is registered; the translation is combinational.
module remap_direct
    import ram_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bank_cfg_t         bank_cfg,
    input  logic [DW-1:0]     dir_addr,
    output logic [PHYS_W-1:0] dir_phys
);
    logic in_window;

    // Window detect and slice substitution.
    always_comb begin
        in_window = (dir_addr[DW-1:SLICE_W] == WIN_TAG);
        if (bank_cfg.en && in_window)
            dir_phys = {bank_cfg.num, dir_addr[SLICE_W-1:0]};
        else
            dir_phys = {{PAD_W{1'b0}}, dir_addr};
    end

    // R5: redirected accesses land in the selected slice at the same offset
    assert_window_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_cfg.en && dir_addr >= 8'h40 && dir_addr <= 8'h7F)
        |-> (dir_phys / 64 == PHYS_W'(bank_cfg.num) && dir_phys % 64 == PHYS_W'(dir_addr % 64)));

    // R6: everything else keeps its address
    assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_cfg.en || dir_addr < 8'h40 || dir_addr > 8'h7F)
        |-> (dir_phys == PHYS_W'(dir_addr)));
endmodule

// File: rtl/remap_ext.sv
// Module: remap_ext
// Builds the physical address for 8-bit indirect external accesses from
// the page code, and blocks writes and returns 0xFF for the empty page.
// Assumes ram_rdata is valid in the same cycle as the address.
module remap_ext
    import ram_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] page,
    input  logic [EXT_W-1:0]  ext_addr,
    input  logic              ext_wr_req,
    input  logic [DW-1:0]     ram_rdata,
    output logic [PHYS_W-1:0] ext_phys,
    output logic              ext_valid,
    output logic              ext_ram_we,
    output logic [DW-1:0]     ext_rdata
);
    // Page concatenation and empty-page gating.
    always_comb begin
        ext_phys   = {page, ext_addr};
        ext_valid  = (page != PAGE_BAD);
        ext_ram_we = ext_wr_req && ext_valid;
        ext_rdata  = ext_valid ? ram_rdata : {DW{1'b1}};
    end

    // R7: valid pages stay below 768 bytes and keep the low byte
    assert_ext_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> (ext_phys < 10'h300 && ext_phys[EXT_W-1:0] == ext_addr));

    // R8: empty page never writes and reads all ones
    assert_page3_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (page == 2'd3) |-> (!ext_ram_we && ext_rdata == 8'hFF));
endmodule

// File: rtl/ram_bank_remap.sv
// Module: ram_bank_remap (top)
// RAM bank address remapper: two mapping registers on a byte-wide register
// bus, a direct-window translator and an indirect external-page translator.
// Assumes one core access per path per cycle; outputs are combinational.
module ram_bank_remap
    import ram_remap_pkg::*;
#(
    parameter logic [7:0] BANK_ADDR = 8'h86,
    parameter logic [7:0] PAGE_ADDR = 8'h85
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_wr,
    input  logic [7:0] sfr_wdata,
    input  logic       sfr_rd,
    output logic [7:0] sfr_rdata,
    output logic       sfr_rd_hit,
    input  logic [7:0] dir_addr,
    output logic [9:0] dir_phys,
    input  logic [7:0] ext_addr,
    input  logic       ext_wr_req,
    input  logic [7:0] ram_rdata,
    output logic [9:0] ext_phys,
    output logic       ext_valid,
    output logic       ext_ram_we,
    output logic [7:0] ext_rdata
);
    bank_cfg_t         bank_cfg;
    logic [PAGE_W-1:0] page_code;

    remap_sfr_regs #(
        .BANK_ADDR (BANK_ADDR),
        .PAGE_ADDR (PAGE_ADDR),
        .BANK_RST  (4'd1)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sfr_addr   (sfr_addr),
        .sfr_wr     (sfr_wr),
        .sfr_wdata  (sfr_wdata),
        .sfr_rd     (sfr_rd),
        .sfr_rdata  (sfr_rdata),
        .sfr_rd_hit (sfr_rd_hit),
        .bank_q     (bank_cfg),
        .page_q     (page_code)
    );

    remap_direct u_direct (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_cfg (bank_cfg),
        .dir_addr (dir_addr),
        .dir_phys (dir_phys)
    );

    remap_ext u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .page       (page_code),
        .ext_addr   (ext_addr),
        .ext_wr_req (ext_wr_req),
        .ram_rdata  (ram_rdata),
        .ext_phys   (ext_phys),
        .ext_valid  (ext_valid),
        .ext_ram_we (ext_ram_we),
        .ext_rdata  (ext_rdata)
    );

    // R4: no read strobe, no answer on the read bus
    assert_rd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_rd |-> (sfr_rdata == 8'h00 && !sfr_rd_hit));

    // R4: an answered read always carries a register address
    assert_rd_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rd_hit |-> (sfr_addr == BANK_ADDR || sfr_addr == PAGE_ADDR));
endmodule

// File: tb/ram_bank_remap_tb.sv
// Bench for ram_bank_remap: a vector table for mapping cases walked by one
// loop, then directed tests for reset, register decode and corner cases.
module ram_bank_remap_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic       sfr_rd = 1'b0;
    logic [7:0] sfr_rdata;
    logic       sfr_rd_hit;
    logic [7:0] dir_addr = 8'h00;
    logic [9:0] dir_phys;
    logic [7:0] ext_addr = 8'h00;
    logic       ext_wr_req = 1'b0;
    logic [7:0] ram_rdata = 8'h00;
    logic [9:0] ext_phys;
    logic       ext_valid;
    logic       ext_ram_we;
    logic [7:0] ext_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ram_bank_remap u_dut (
        .clk(clk), .rst_n(rst_n),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata), .sfr_rd_hit(sfr_rd_hit),
        .dir_addr(dir_addr), .dir_phys(dir_phys),
        .ext_addr(ext_addr), .ext_wr_req(ext_wr_req), .ram_rdata(ram_rdata),
        .ext_phys(ext_phys), .ext_valid(ext_valid), .ext_ram_we(ext_ram_we),
        .ext_rdata(ext_rdata)
    );

    always #10 clk = ~clk; // 50 MHz

    // Vector: {bank byte, page byte, dir_addr, ext_addr, exp dir_phys, exp ext_phys, exp valid}
    localparam int NV = 8;
    localparam logic [52:0] VEC [0:NV-1] = '{
        {8'h85, 8'h00, 8'h40, 8'h12, 10'h140, 10'h012, 1'b1},
        {8'h8F, 8'h01, 8'h7F, 8'hFF, 10'h3FF, 10'h1FF, 1'b1},
        {8'h80, 8'h02, 8'h55, 8'h00, 10'h015, 10'h200, 1'b1},
        {8'h05, 8'h02, 8'h55, 8'h80, 10'h055, 10'h280, 1'b1},
        {8'h83, 8'h00, 8'h3F, 8'h7F, 10'h03F, 10'h07F, 1'b1},
        {8'h83, 8'h01, 8'h80, 8'h01, 10'h080, 10'h101, 1'b1},
        {8'h8A, 8'h03, 8'hC0, 8'h44, 10'h0C0, 10'h000, 1'b0},
        {8'hF1, 8'hFE, 8'h6A, 8'h33, 10'h06A, 10'h233, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
        #1;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d, output logic h);
        @(negedge clk);
        sfr_addr = a; sfr_rd = 1'b1;
        #2;
        d = sfr_rdata; h = sfr_rd_hit;
        @(negedge clk);
        sfr_rd = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       hit;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        sfr_read(8'h86, rd, hit); chk("R1 bank reset", {8'h0, rd}, 16'h0001);
        sfr_read(8'h85, rd, hit); chk("R1 page reset", {8'h0, rd}, 16'h0000);
        dir_addr = 8'h50; #1;
        chk("R6 disabled after reset", {6'h0, dir_phys}, 16'h0050);

        // Table walk (R5, R6, R7, R8)
        for (int i = 0; i < NV; i++) begin
            sfr_write(8'h86, VEC[i][52:45]);
            sfr_write(8'h85, VEC[i][44:37]);
            dir_addr = VEC[i][36:29];
            ext_addr = VEC[i][28:21];
            #1;
            chk("R5/R6 dir map", {6'h0, dir_phys}, {6'h0, VEC[i][20:11]});
            chk("R7/R8 ext valid", {15'h0, ext_valid}, {15'h0, VEC[i][0]});
            if (VEC[i][0])
                chk("R7 ext map", {6'h0, ext_phys}, {6'h0, VEC[i][10:1]});
        end

        // R4: read decode
        sfr_read(8'h87, rd, hit); chk("R4 foreign rdata", {8'h0, rd}, 16'h0000);
        chk("R4 foreign hit", {15'h0, hit}, 16'h0000);
        sfr_read(8'h85, rd, hit); chk("R4 page hit", {15'h0, hit}, 16'h0001);
        #1; chk("R4 idle rdata", {7'h0, sfr_rd_hit, sfr_rdata}, 16'h0000);

        // R2 / R3: unused bits
        sfr_write(8'h86, 8'hFF);
        sfr_read(8'h86, rd, hit); chk("R2 bank unused bits", {8'h0, rd}, 16'h008F);
        sfr_write(8'h85, 8'hFF);
        sfr_read(8'h85, rd, hit); chk("R3 page unused bits", {8'h0, rd}, 16'h0003);

        // R8: empty page blocks write, reads 0xFF
        ext_wr_req = 1'b1; ram_rdata = 8'h5A; #1;
        chk("R8 we blocked", {15'h0, ext_ram_we}, 16'h0000);
        chk("R8 rdata ff", {8'h0, ext_rdata}, 16'h00FF);
        sfr_write(8'h85, 8'h01);
        chk("R8 we passes", {15'h0, ext_ram_we}, 16'h0001);
        chk("R8 rdata passes", {8'h0, ext_rdata}, 16'h005A);
        ext_wr_req = 1'b0; #1;
        chk("R8 no req no we", {15'h0, ext_ram_we}, 16'h0000);

        // R9: foreign writes ignored
        sfr_write(8'h84, 8'h00);
        sfr_write(8'h87, 8'h00);
        sfr_write(8'h06, 8'h00);
        sfr_read(8'h86, rd, hit); chk("R9 bank kept", {8'h0, rd}, 16'h008F);
        sfr_read(8'h85, rd, hit); chk("R9 page kept", {8'h0, rd}, 16'h0001);

        // R10: mapping changes right after the capturing edge
        dir_addr = 8'h41; ext_addr = 8'h10;
        sfr_write(8'h86, 8'h82);
        chk("R10 dir new bank", {6'h0, dir_phys}, 16'h0081);
        sfr_write(8'h85, 8'h02);
        chk("R10 ext new page", {6'h0, ext_phys}, 16'h0210);
        sfr_write(8'h86, 8'h02);
        chk("R10 disable at once", {6'h0, dir_phys}, 16'h0041);

        // R1: reset in mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        sfr_read(8'h86, rd, hit); chk("R1 bank re-reset", {8'h0, rd}, 16'h0001);
        sfr_read(8'h85, rd, hit); chk("R1 page re-reset", {8'h0, rd}, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule